// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is the control half of a scoreboarded floating-point back end. It accepts an in-order stream of operations, each with an operation code, one destination register and two source registers. It steers each operation to one of five functional units: an integer/load unit, two multipliers, an adder that also subtracts, and a divider. From there it lets every unit move on its own through four steps: accepted, operands read, execution finished and result written. The unit datapaths and the register values are outside the block. The block only grants the moments at which a unit may read its operands and write its result, and it hears back from each unit through a one-cycle completion pulse.

The block keeps a status record for every unit. The record holds the busy flag, the step reached, the operation, the destination and source register numbers, the producing unit of each source, and a ready flag per source. The block also keeps a table with one entry per register. Each entry names the unit that will write that register, or holds zero when no write is pending. Issue is in order and blocks on a busy unit or on a pending writer of the same destination. Operand reads wait for true data dependences. Result writes wait while an earlier-issued unit still needs the old value. The register file has a single write port.

Top module: `scoreboard_ctrl`

## Requirements
- R1: Operation codes map to units as follows: 0 load goes to unit 0, 1 multiply goes to unit 1 or 2, 2 add and 3 subtract go to unit 3, 4 divide goes to unit 4. A multiply takes the lower-numbered free multiplier. `issue_ok` rises in the same cycle as `in_valid` when the unit is free and there is no pending writer of the destination.
- R2: When no unit of the needed kind is free, `issue_ok` stays low and the presented operation is held. No later operation is accepted until the held one is.
- R3: An operation whose destination already has a pending writer is not accepted. It is accepted in the cycle after that writer's write grant at the earliest.
- R4: A unit gets `rd_grant` only when neither of its sources has a pending writer. The earliest grant is in the cycle after the unit's issue.
- R5: A unit is granted operand read once per operation. Once it has read, it no longer holds back any writer.
- R6: An `ex_done` pulse counts only for a unit that has read its operands and not yet finished. In any other step the pulse is ignored.
- R7: A write grant comes at the earliest in the cycle after the unit's `ex_done` pulse. `wr_reg` carries the unit's destination. The unit is free again from the next cycle.
- R8: A finished unit may not write while another busy unit has a source equal to its destination and has not yet read it. The write follows in the cycle after that read.
- R9: A write grant marks as ready every waiting source that named the writer. A consumer with no other pending source gets `rd_grant` in the next cycle.
- R10: If an operation is accepted in the same cycle that the producer of one of its sources is granted the write, that source counts as ready at once.
- R11: When several units may write in the same cycle, only one is granted. The fixed order is divider, adder, second multiplier, first multiplier, load.
- R12: Several units can be granted operand read in the same cycle.
- R13: While `rst` is high, `issue_ok`, `rd_grant` and `wr_grant` are all low. After reset every unit is free and no register has a pending writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented |
| in_op | input | 3 | Operation code (see R1) |
| in_dst | input | 5 | Destination register number |
| in_src1 | input | 5 | First source register number |
| in_src2 | input | 5 | Second source register number |
| issue_ok | output | 1 | The presented operation is accepted this cycle |
| ex_done | input | 5 | Per-unit completion pulse |
| rd_grant | output | 5 | Per-unit operand-read grant |
| wr_grant | output | 5 | Per-unit result-write grant, at most one bit set |
| wr_reg | output | 5 | Register written under the current write grant |

## Verification
Two events can fall in the same cycle. The first pair is one unit's operand read and another unit's blocked write-back, when the reader's source is the writer's destination. A long divide holds a multiply back on one source while the multiply's other source names the destination of a short add. The add therefore finishes first and must wait. The bench checks that the write grant comes in the cycle after the read, never together with it. The second pair is a write grant and the acceptance of an operation that consumes the written register. It is provoked by inserting idle cycles so that the consumer arrives exactly in the writer's cycle, and the consumer must read in the next cycle. A cycle-level reference model in the bench predicts every grant. Random streams with few registers and random latencies add more such collisions.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int NUM_FU  = 5;
    parameter int NUM_REG = 32;
    localparam int REG_W  = $clog2(NUM_REG);
    localparam int CODE_W = $clog2(NUM_FU + 1);
    localparam int OP_W   = 3;

    localparam int FU_INT  = 0;
    localparam int FU_MUL0 = 1;
    localparam int FU_MUL1 = 2;
    localparam int FU_ADD  = 3;
    localparam int FU_DIV  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 3'd0,
        OP_MUL  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_DIV  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_OPS,
        ST_EXEC,
        ST_DONE
    } step_e;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic            busy;
        step_e           step;
        logic [OP_W-1:0] op;
        reg_t            fi;
        reg_t            fj;
        reg_t            fk;
        code_t           qj;
        code_t           qk;
        logic            rj;
        logic            rk;
    } fu_t;

    function automatic logic [NUM_FU-1:0] unit_class(input logic [OP_W-1:0] op);
        logic [NUM_FU-1:0] m;
        m = '0;
        case (op)
            OP_LOAD:        m[FU_INT] = 1'b1;
            OP_MUL:         begin m[FU_MUL0] = 1'b1; m[FU_MUL1] = 1'b1; end
            OP_ADD, OP_SUB: m[FU_ADD] = 1'b1;
            OP_DIV:         m[FU_DIV] = 1'b1;
            default:        m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  logic                    in_valid,
    input  logic [OP_W-1:0]         in_op,
    input  reg_t                    in_dst,
    input  reg_t                    in_src1,
    input  reg_t                    in_src2,
    input  logic [NUM_FU-1:0]       busy_vec,
    input  code_t [NUM_REG-1:0]     owner,
    input  logic                    wr_fire,
    input  code_t                   wr_code,
    output logic                    accept,
    output logic [NUM_FU-1:0]       sel,
    output code_t                   qj,
    output code_t                   qk
);
    logic [NUM_FU-1:0] free_cand;

    always_comb begin
        free_cand = unit_class(in_op) & ~busy_vec;
        sel = '0;
        for (int u = NUM_FU - 1; u >= 0; u--) begin
            if (free_cand[u]) begin
                sel    = '0;
                sel[u] = 1'b1;
            end
        end
        accept = in_valid && (|free_cand) && (owner[in_dst] == '0);
        qj = owner[in_src1];
        if (wr_fire && qj == wr_code) qj = '0;
        qk = owner[in_src2];
        if (wr_fire && qk == wr_code) qk = '0;
    end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
    import sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_en,
    input  logic [OP_W-1:0] in_op,
    input  reg_t            in_dst,
    input  reg_t            in_src1,
    input  reg_t            in_src2,
    input  code_t           qj_in,
    input  code_t           qk_in,
    input  logic            rd_go,
    input  logic            done_in,
    input  logic            wr_go,
    input  logic            wr_fire,
    input  code_t           wr_code,
    output fu_t             state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (issue_en) begin
            state.busy <= 1'b1;
            state.step <= ST_WAIT_OPS;
            state.op   <= in_op;
            state.fi   <= in_dst;
            state.fj   <= in_src1;
            state.fk   <= in_src2;
            state.qj   <= qj_in;
            state.qk   <= qk_in;
            state.rj   <= (qj_in == '0);
            state.rk   <= (qk_in == '0);
        end else begin
            if (rd_go) begin
                state.step <= ST_EXEC;
                state.rj   <= 1'b0;
                state.rk   <= 1'b0;
            end
            if (state.step == ST_EXEC && done_in) begin
                state.step <= ST_DONE;
            end
            if (wr_go) begin
                state.busy <= 1'b0;
                state.step <= ST_IDLE;
            end
            if (wr_fire && state.step == ST_WAIT_OPS) begin
                if (state.qj == wr_code) begin
                    state.rj <= 1'b1;
                    state.qj <= '0;
                end
                if (state.qk == wr_code) begin
                    state.rk <= 1'b1;
                    state.qk <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/sb_wb_pick.sv
module sb_wb_pick
    import sb_pkg::*;
(
    input  fu_t [NUM_FU-1:0]  fu_vec,
    output logic [NUM_FU-1:0] grant,
    output logic              fire,
    output code_t             code,
    output reg_t              dst
);
    logic [NUM_FU-1:0] clash;
    logic [NUM_FU-1:0] elig;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            clash[u] = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u && fu_vec[f].busy &&
                    ((fu_vec[f].fj == fu_vec[u].fi && fu_vec[f].rj) ||
                     (fu_vec[f].fk == fu_vec[u].fi && fu_vec[f].rk)))
                    clash[u] = 1'b1;
            end
            elig[u] = fu_vec[u].busy && fu_vec[u].step == ST_DONE && !clash[u];
        end
        grant = '0;
        code  = '0;
        dst   = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (elig[u]) begin
                grant    = '0;
                grant[u] = 1'b1;
                code     = code_t'(u + 1);
                dst      = fu_vec[u].fi;
            end
        end
        fire = |elig;
    end
endmodule

// File: rtl/sb_result_tbl.sv
module sb_result_tbl
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  reg_t                set_reg,
    input  code_t               set_code,
    input  logic                clr_en,
    input  reg_t                clr_reg,
    output code_t [NUM_REG-1:0] owner
);
    always_ff @(posedge clk) begin
        if (rst) begin
            owner <= '0;
        end else begin
            if (clr_en) owner[clr_reg] <= '0;
            if (set_en) owner[set_reg] <= set_code;
        end
    end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              issue_ok,
    input  logic [NUM_FU-1:0] ex_done,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wr_grant,
    output logic [REG_W-1:0]  wr_reg
);
    fu_t   [NUM_FU-1:0]  fu_vec;
    code_t [NUM_REG-1:0] owner;
    logic  [NUM_FU-1:0]  busy_vec;
    logic  [NUM_FU-1:0]  sel;
    logic                accept;
    code_t               qj_new;
    code_t               qk_new;
    code_t               sel_code;
    code_t               wr_code;
    logic                wr_fire;
    reg_t                wr_dst;

    sb_issue_ctl u_issue (
        .in_valid (in_valid),
        .in_op    (in_op),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .busy_vec (busy_vec),
        .owner    (owner),
        .wr_fire  (wr_fire),
        .wr_code  (wr_code),
        .accept   (accept),
        .sel      (sel),
        .qj       (qj_new),
        .qk       (qk_new)
    );

    assign issue_ok = accept & ~rst;

    always_comb begin
        sel_code = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (sel[u]) sel_code = code_t'(u + 1);
        end
    end

    for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
        assign busy_vec[u] = fu_vec[u].busy;
        assign rd_grant[u] = fu_vec[u].busy && fu_vec[u].step == ST_WAIT_OPS &&
                             fu_vec[u].rj && fu_vec[u].rk;
        sb_unit_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .issue_en (issue_ok & sel[u]),
            .in_op    (in_op),
            .in_dst   (in_dst),
            .in_src1  (in_src1),
            .in_src2  (in_src2),
            .qj_in    (qj_new),
            .qk_in    (qk_new),
            .rd_go    (rd_grant[u]),
            .done_in  (ex_done[u]),
            .wr_go    (wr_grant[u]),
            .wr_fire  (wr_fire),
            .wr_code  (wr_code),
            .state    (fu_vec[u])
        );
    end

    sb_wb_pick u_wb (
        .fu_vec (fu_vec),
        .grant  (wr_grant),
        .fire   (wr_fire),
        .code   (wr_code),
        .dst    (wr_dst)
    );

    assign wr_reg = wr_dst;

    sb_result_tbl u_tbl (
        .clk      (clk),
        .rst      (rst),
        .set_en   (issue_ok),
        .set_reg  (in_dst),
        .set_code (sel_code),
        .clr_en   (wr_fire),
        .clr_reg  (wr_dst),
        .owner    (owner)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              issue_ok,
    input logic [NUM_FU-1:0] ex_done,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant
);
    logic [NUM_FU-1:0] has_read;
    logic [NUM_FU-1:0] has_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            has_read <= '0;
            has_done <= '0;
        end else begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (wr_grant[u]) begin
                    has_read[u] <= 1'b0;
                    has_done[u] <= 1'b0;
                end else begin
                    if (rd_grant[u]) has_read[u] <= 1'b1;
                    if (has_read[u] && ex_done[u]) has_done[u] <= 1'b1;
                end
            end
        end
    end

    p_accept_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> in_valid) else $error("accept without valid");

    p_single_writer_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_grant)) else $error("more than one write grant");

    for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
        p_read_once_r5: assert property (@(posedge clk) disable iff (rst)
            rd_grant[u] |-> !has_read[u]) else $error("second operand read");

        p_write_after_done_r7: assert property (@(posedge clk) disable iff (rst)
            wr_grant[u] |-> has_done[u]) else $error("write before completion");

        p_unit_freed_r7: assert property (@(posedge clk) disable iff (rst)
            wr_grant[u] |=> !wr_grant[u]) else $error("write granted twice");
    end
endmodule

bind scoreboard_ctrl sb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .issue_ok (issue_ok),
    .ex_done  (ex_done),
    .rd_grant (rd_grant),
    .wr_grant (wr_grant)
);

// File: tb/tb_scoreboard_ctrl.sv
module tb_scoreboard_ctrl;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              in_valid = 1'b0;
    logic [OP_W-1:0]   in_op = '0;
    logic [REG_W-1:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic              issue_ok;
    logic [NUM_FU-1:0] ex_done = '0;
    logic [NUM_FU-1:0] rd_grant, wr_grant;
    logic [REG_W-1:0]  wr_reg;

    scoreboard_ctrl dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_ok(issue_ok), .ex_done(ex_done), .rd_grant(rd_grant),
        .wr_grant(wr_grant), .wr_reg(wr_reg)
    );

    int total = 0;
    int bad = 0;

    // reference model state
    int m_busy[NUM_FU], m_st[NUM_FU], m_fi[NUM_FU], m_fj[NUM_FU], m_fk[NUM_FU];
    int m_qj[NUM_FU], m_qk[NUM_FU], m_rj[NUM_FU], m_rk[NUM_FU];
    int m_res[NUM_REG];
    int rem[NUM_FU], lat[NUM_FU];
    int p_op[$], p_d[$], p_s1[$], p_s2[$], p_gap[$];
    int pc, gap_cnt, multi_rd_seen, first_wr;
    bit rand_mode;
    string tag;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int class_mask(input int op);
        case (op)
            0: return 1 << 0;
            1: return (1 << 1) | (1 << 2);
            2, 3: return 1 << 3;
            4: return 1 << 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_clear();
        for (int u = 0; u < NUM_FU; u++) begin
            m_busy[u] = 0; m_st[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
            m_qj[u] = 0; m_qk[u] = 0; m_rj[u] = 0; m_rk[u] = 0; rem[u] = 0;
        end
        for (int r = 0; r < NUM_REG; r++) m_res[r] = 0;
    endtask

    task automatic put(input int op, input int d, input int s1, input int s2, input int gap);
        p_op.push_back(op); p_d.push_back(d); p_s1.push_back(s1);
        p_s2.push_back(s2); p_gap.push_back(gap);
    endtask

    task automatic step();
        logic [NUM_FU-1:0] e_rd, e_wr;
        bit e_ok, blk;
        int e_sel, e_w, wc, nq1, nq2, d, s1, s2;
        int ost[NUM_FU];
        @(posedge clk);
        #1;
        if (pc < p_op.size() && gap_cnt >= p_gap[pc]) begin
            in_valid = 1'b1;
            in_op   = p_op[pc][OP_W-1:0];
            in_dst  = p_d[pc][REG_W-1:0];
            in_src1 = p_s1[pc][REG_W-1:0];
            in_src2 = p_s2[pc][REG_W-1:0];
        end else begin
            in_valid = 1'b0;
        end
        ex_done = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (rem[u] > 0) begin
                rem[u]--;
                if (rem[u] == 0) ex_done[u] = 1'b1;
            end else if (rand_mode && m_st[u] != 2 && $urandom_range(0, 7) == 0) begin
                ex_done[u] = 1'b1;   // stray pulse, must be ignored (R6)
            end
        end
        #3;
        // expected outputs from model state
        e_rd = '0; e_wr = '0; e_w = -1; e_sel = -1;
        for (int u = 0; u < NUM_FU; u++) begin
            e_rd[u] = (m_busy[u] != 0 && m_st[u] == 1 && m_rj[u] != 0 && m_rk[u] != 0);
            if (m_busy[u] != 0 && m_st[u] == 3) begin
                blk = 0;
                for (int f = 0; f < NUM_FU; f++)
                    if (f != u && m_busy[f] != 0 &&
                        ((m_fj[f] == m_fi[u] && m_rj[f] != 0) || (m_fk[f] == m_fi[u] && m_rk[f] != 0)))
                        blk = 1;
                if (!blk) e_w = u;
            end
        end
        if (e_w >= 0) e_wr[e_w] = 1'b1;
        d = int'(in_dst); s1 = int'(in_src1); s2 = int'(in_src2);
        for (int u = NUM_FU - 1; u >= 0; u--)
            if (class_mask(int'(in_op))[u] && m_busy[u] == 0) e_sel = u;
        e_ok = in_valid && e_sel >= 0 && m_res[d] == 0;
        check(issue_ok === e_ok, tag, "issue_ok", int'(issue_ok), int'(e_ok));
        check(rd_grant === e_rd, tag, "rd_grant", int'(rd_grant), int'(e_rd));
        check(wr_grant === e_wr, tag, "wr_grant", int'(wr_grant), int'(e_wr));
        if (e_w >= 0) check(int'(wr_reg) == m_fi[e_w], tag, "wr_reg", int'(wr_reg), m_fi[e_w]);
        if ($countones(rd_grant) >= 2) multi_rd_seen++;
        if (first_wr < 0 && wr_grant != '0) first_wr = int'(wr_grant);
        // environment: unit latencies start on a read grant
        for (int u = 0; u < NUM_FU; u++)
            if (rd_grant[u]) rem[u] = rand_mode ? $urandom_range(1, 6) : lat[u];
        // model update
        wc = (e_w >= 0) ? e_w + 1 : 0;
        for (int u = 0; u < NUM_FU; u++) ost[u] = m_st[u];
        nq1 = m_res[s1]; if (wc != 0 && nq1 == wc) nq1 = 0;
        nq2 = m_res[s2]; if (wc != 0 && nq2 == wc) nq2 = 0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (e_ok && u == e_sel) begin
                m_busy[u] = 1; m_st[u] = 1; m_fi[u] = d; m_fj[u] = s1; m_fk[u] = s2;
                m_qj[u] = nq1; m_qk[u] = nq2;
                m_rj[u] = (nq1 == 0) ? 1 : 0; m_rk[u] = (nq2 == 0) ? 1 : 0;
            end else begin
                if (e_rd[u]) begin m_st[u] = 2; m_rj[u] = 0; m_rk[u] = 0; end
                if (ost[u] == 2 && ex_done[u]) m_st[u] = 3;
                if (u == e_w) begin m_busy[u] = 0; m_st[u] = 0; end
                if (wc != 0 && ost[u] == 1) begin
                    if (m_qj[u] == wc) begin m_rj[u] = 1; m_qj[u] = 0; end
                    if (m_qk[u] == wc) begin m_rk[u] = 1; m_qk[u] = 0; end
                end
            end
        end
        if (e_w >= 0) m_res[m_fi[e_w]] = 0;
        if (e_ok) m_res[d] = e_sel + 1;
        if (in_valid) begin
            if (e_ok) begin pc++; gap_cnt = 0; end
        end else begin
            gap_cnt++;
        end
    endtask

    task automatic run(input string t);
        bit idle;
        tag = t; pc = 0; gap_cnt = 0; multi_rd_seen = 0; first_wr = -1;
        for (int k = 0; k < 20000; k++) begin
            step();
            idle = (pc >= p_op.size());
            for (int u = 0; u < NUM_FU; u++) if (m_busy[u] != 0 || rem[u] != 0) idle = 0;
            if (idle) break;
        end
        step(); step();
        check(pc == p_op.size(), t, "program drained", pc, p_op.size());
        p_op.delete(); p_d.delete(); p_s1.delete(); p_s2.delete(); p_gap.delete();
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog expired in %s", tag);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        model_clear();
        rand_mode = 0;
        tag = "R13";
        // R13: reset holds every grant low even with a valid operation present
        rst = 1'b1; in_valid = 1'b1; in_op = 3'd2; in_dst = 5'd3;
        repeat (2) @(posedge clk);
        #4;
        check(issue_ok === 1'b0, "R13", "issue_ok in reset", int'(issue_ok), 0);
        check(rd_grant === '0, "R13", "rd_grant in reset", int'(rd_grant), 0);
        check(wr_grant === '0, "R13", "wr_grant in reset", int'(wr_grant), 0);
        @(posedge clk); #1; rst = 1'b0; in_valid = 1'b0;
        lat[0] = 2; lat[1] = 4; lat[2] = 4; lat[3] = 2; lat[4] = 6;

        // R1/R13: independent operations, one to each unit, first accepted at once
        put(0, 1, 20, 21, 0); put(1, 2, 22, 23, 0); put(1, 3, 22, 24, 0);
        put(2, 4, 25, 26, 0); put(4, 5, 26, 27, 0);
        run("R1");

        // R12: two consumers released by the same write read together (R9 broadcast)
        put(0, 1, 20, 21, 0); put(1, 2, 1, 20, 0); put(3, 3, 1, 21, 0);
        run("R12/R9");
        check(multi_rd_seen > 0, "R12", "simultaneous reads", multi_rd_seen, 1);

        // R2: second adder operation waits for the unit
        put(2, 1, 20, 21, 0); put(3, 2, 22, 23, 0); put(0, 6, 20, 20, 0);
        run("R2");

        // R3: same destination on different units
        put(1, 6, 20, 21, 0); put(2, 6, 22, 23, 0);
        run("R3");

        // R4/R7/R9: dependence chain
        put(0, 1, 20, 21, 0); put(2, 2, 1, 1, 0); put(1, 7, 2, 1, 0);
        run("R4/R7/R9");

        // R8/R5: short add must wait until the multiply has read the old value
        lat[4] = 10; lat[3] = 1;
        put(4, 0, 2, 4, 0); put(1, 10, 0, 8, 0); put(2, 8, 20, 21, 0);
        run("R8/R5");

        // R10: consumer arrives in the producer's write cycle
        lat[0] = 2; lat[4] = 6; lat[3] = 2;
        put(0, 1, 20, 21, 0); put(2, 5, 1, 20, 3);
        run("R10");

        // R11: load and divide finish together, divide wins the port
        lat[0] = 2; lat[4] = 1;
        put(0, 1, 20, 21, 0); put(4, 2, 22, 23, 0);
        run("R11");
        check(first_wr == (1 << FU_DIV), "R11", "first writer", first_wr, 1 << FU_DIV);

        // R6 and mixed: random stream, few registers, random latencies, stray pulses
        rand_mode = 1;
        for (int i = 0; i < 400; i++)
            put($urandom_range(0, 4), $urandom_range(0, 7), $urandom_range(0, 7),
                $urandom_range(0, 7), ($urandom_range(0, 5) == 0) ? $urandom_range(1, 3) : 0);
        run("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule